// File: doc/BRIEF.md
# Prescaled Auto-Reload Countdown Timer

This block is a 32-bit down-counter behind a small word-addressed register port. Software places a start value in the load register, selects a prescale factor and the restart behaviour in the control register, and sets the enable bit. While it is enabled, the counter drops by one after every (P+1) clock cycles, where P is the prescale field. When the count runs out, a sticky status bit is set, and the interrupt output follows that bit as a level.

In one-shot operation the counter stops at zero after it expires. In periodic operation it takes the load value again and keeps running, so the interrupt repeats at a fixed period. Software clears the status bit by writing a one to it. The register port has no handshake. A write takes effect on the clock edge where the write enable is sampled high. Read data is combinational from the address and is valid in the same cycle. The block never stalls, so there is no back-pressure. The interrupt is a plain level output.

Top module: `cdt_timer`

## Requirements
- R1: After reset, every register (byte offsets 0x0, 0x4, 0x8, 0xC) reads zero and the interrupt output is low.
- R2: The register map is load at 0x0, counter at 0x4, control at 0x8 and status at 0xC. Control bit 0 is enable, bit 1 is auto-reload and bits 15:8 are the prescale value P. Control reads back only those fields, with all other bits zero. Any other offset reads zero and a write to it changes nothing.
- R3: While enabled, the counter decrements once per (P+1) clock cycles. A counter holding L that is enabled by a write at clock edge E expires at edge E + L*(P+1). While disabled, the counter holds its value.
- R4: On expiry with auto-reload off, the counter stays at zero and counting stops.
- R5: On expiry with auto-reload on, the counter takes the load value and keeps counting, so the next expiry follows L*(P+1) cycles later.
- R6: A write to the load offset sets both the load register and the counter. A write to the counter offset sets only the counter. Either write restarts the prescale phase, so the first decrement after it comes a full (P+1) cycles later.
- R7: A control write that takes enable from 0 to 1 while the counter is zero and auto-reload is set in the written value first copies the load register into the counter. Without auto-reload, the counter stays zero.
- R8: A counter that holds zero never expires and never sets the status bit.
- R9: A read of the counter offset returns zero while the timer is disabled, whatever the counter holds.
- R10: Expiry sets status bit 0, and the interrupt output equals that bit. Writing 1 to bit 0 of the status offset clears it, and writing 0 has no effect. If a clear and an expiry fall on the same edge, the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (4) | Byte offset of the register access |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| irq | output | 1 | Level interrupt, equal to the status bit |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, an 8-bit prescale field and a 4-bit byte offset. With a 4-bit offset, every unmapped offset in the window can be reached. Load values stay small, between 1 and 20, and prescale values between 0 and 3, so a full expiry fits in a few dozen cycles. This lets many one-shot and periodic runs be timed to the exact edge. Directed cases cover the zero-count preload, a counter rewrite part-way through a prescale phase, and a status clear that lands on the same edge as an expiry.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // Byte offsets of the registers.
  localparam int unsigned OFF_LOAD  = 32'h0;
  localparam int unsigned OFF_COUNT = 32'h4;
  localparam int unsigned OFF_CTRL  = 32'h8;
  localparam int unsigned OFF_STAT  = 32'hC;

  // Control field positions.
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_AR_BIT  = 1;
  localparam int unsigned CTRL_PSC_LSB = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOAD,
    SEL_COUNT,
    SEL_CTRL,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/cdt_regif.sv
module cdt_regif
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  load_q,
  input  logic [CNT_W-1:0]  count_q,
  input  logic              stat_q,
  output logic              wr_load,
  output logic              wr_count,
  output logic              stat_clr,
  output logic              en_rise,
  output logic              preload_req,
  output logic              en_q,
  output logic              ar_q,
  output logic [PSC_W-1:0]  psc_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PSC_MSB = CTRL_PSC_LSB + PSC_W - 1;

  reg_sel_e sel;
  logic     wr_ctrl;

  always_comb begin
    unique case (32'(addr))
      OFF_LOAD:  sel = SEL_LOAD;
      OFF_COUNT: sel = SEL_COUNT;
      OFF_CTRL:  sel = SEL_CTRL;
      OFF_STAT:  sel = SEL_STAT;
      default:   sel = SEL_NONE;
    endcase
  end

  assign wr_load     = we && (sel == SEL_LOAD);
  assign wr_count    = we && (sel == SEL_COUNT);
  assign wr_ctrl     = we && (sel == SEL_CTRL);
  assign stat_clr    = we && (sel == SEL_STAT) && wdata[0];
  assign en_rise     = wr_ctrl && !en_q && wdata[CTRL_EN_BIT];
  assign preload_req = en_rise && wdata[CTRL_AR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ar_q  <= 1'b0;
      psc_q <= '0;
    end else if (wr_ctrl) begin
      en_q  <= wdata[CTRL_EN_BIT];
      ar_q  <= wdata[CTRL_AR_BIT];
      psc_q <= wdata[PSC_MSB:CTRL_PSC_LSB];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_LOAD:  rdata = DATA_W'(load_q);
      SEL_COUNT: rdata = en_q ? DATA_W'(count_q) : '0;
      SEL_CTRL: begin
        rdata[CTRL_EN_BIT]           = en_q;
        rdata[CTRL_AR_BIT]           = ar_q;
        rdata[PSC_MSB:CTRL_PSC_LSB]  = psc_q;
      end
      SEL_STAT:  rdata[0] = stat_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q;

  // The >= test keeps the period bounded if P shrinks mid-phase.
  assign tick = en && !restart && (phase_q >= psc);

  always_ff @(posedge clk) begin
    if (!rst_n)              phase_q <= '0;
    else if (!en || restart) phase_q <= '0;
    else if (phase_q >= psc) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_load,
  input  logic             wr_count,
  input  logic [CNT_W-1:0] wval,
  input  logic             preload_req,
  input  logic             ar,
  input  logic             tick,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = tick && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
    end else if (wr_load) begin
      load_q  <= wval;
      count_q <= wval;
    end else if (wr_count) begin
      count_q <= wval;
    end else if (preload_req && (count_q == '0)) begin
      count_q <= load_q;
    end else if (tick && (count_q != '0)) begin
      if (count_q == ONE) count_q <= ar ? load_q : '0;
      else                count_q <= count_q - ONE;
    end
  end
endmodule

// File: rtl/cdt_status.sv
module cdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      stat_q <= 1'b0;
    else if (expire) stat_q <= 1'b1;
    else if (clr)    stat_q <= 1'b0;
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic             wr_load, wr_count, stat_clr, en_rise, preload_req;
  logic             en_q, ar_q, stat_q, tick, expire;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] load_q, count_q;

  cdt_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .load_q(load_q), .count_q(count_q), .stat_q(stat_q),
    .wr_load(wr_load), .wr_count(wr_count), .stat_clr(stat_clr),
    .en_rise(en_rise), .preload_req(preload_req),
    .en_q(en_q), .ar_q(ar_q), .psc_q(psc_q), .rdata(reg_rdata)
  );

  cdt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(en_q),
    .restart(wr_load || wr_count || en_rise),
    .psc(psc_q), .tick(tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_load(wr_load), .wr_count(wr_count),
    .wval(reg_wdata[CNT_W-1:0]), .preload_req(preload_req), .ar(ar_q),
    .tick(tick), .load_q(load_q), .count_q(count_q), .expire(expire)
  );

  cdt_status u_stat (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr(stat_clr), .stat_q(stat_q)
  );

  assign irq = stat_q;
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic              en_q,
  input logic              ar_q,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  load_q,
  input logic              expire
);
  logic clr_wr;
  assign clr_wr = reg_we && (32'(reg_addr) == OFF_STAT) && reg_wdata[0];

  AST_EXPIRE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq); // R10

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_wr |=> irq); // R10

  AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !ar_q |=> count_q == '0); // R4

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ar_q |=> count_q == $past(load_q)); // R5

  AST_IRQ_NEEDS_LIVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en_q) && ($past(count_q) == CNT_W'(1))); // R8

  AST_DISABLED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && (32'(reg_addr) == OFF_COUNT) |-> reg_rdata == '0); // R9

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !reg_we |=> $stable(count_q)); // R3
endmodule

bind cdt_timer cdt_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
  .en_q(en_q), .ar_q(ar_q), .count_q(count_q), .load_q(load_q),
  .expire(expire)
);

// File: tb/cdt_timer_tb.sv
`timescale 1ns/1ps
module cdt_timer_tb;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam logic [3:0] A_LOAD = 4'h0, A_CNT = 4'h4, A_CTRL = 4'h8, A_STAT = 4'hC;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_we = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  cdt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // Expected control read-back: only enable, auto-reload and prescale survive (R2).
  function automatic logic [31:0] ctrl_view(input logic [31:0] w);
    return {16'h0, w[15:8], 6'h0, w[1:0]};
  endfunction

  function automatic logic [31:0] ctrl_word(input int p, input bit ar, input bit en);
    return (32'(p) << 8) | (32'(ar) << 1) | 32'(en);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks run in the low clock phase; a write lands on the next rising edge.
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_LOAD, v); chk("R1 load", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 control fields and unmapped offsets
    wr(A_CTRL, 32'hFFFF_AB02);
    rd(A_CTRL, v); chk("R2 ctrl readback", v, ctrl_view(32'hFFFF_AB02));
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'd55);
    wr(4'h2, 32'd99);
    wr(4'h6, 32'd77);
    rd(A_LOAD, v); chk("R2 unmapped write ignored", v, 32'd55);
    rd(4'h6, v);   chk("R2 unmapped read zero", v, 0);
    rd(4'hF, v);   chk("R2 unmapped read zero hi", v, 0);

    // R9 disabled counter reads zero, enabling exposes it
    rd(A_CNT, v); chk("R9 disabled read", v, 0);
    wr(A_CTRL, ctrl_word(10, 0, 1));
    rd(A_CNT, v); chk("R6 load also sets counter", v, 32'd55);
    wr(A_CTRL, ctrl_word(10, 0, 0));
    rd(A_CNT, v); chk("R9 disabled again", v, 0);

    // R7 preload on enable with zero count and auto-reload
    wr(A_LOAD, 32'd7);
    wr(A_CNT, 32'd0);
    rd(A_LOAD, v); chk("R6 counter write leaves load", v, 32'd7);
    wr(A_CTRL, ctrl_word(50, 1, 1));
    rd(A_CNT, v); chk("R7 preload", v, 32'd7);
    wr(A_CTRL, 0);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, ctrl_word(0, 0, 1));
    rd(A_CNT, v); chk("R7 no preload without auto-reload", v, 0);
    // R8 zero count never fires
    cyc(20);
    chk("R8 zero count no irq", 32'(irq), 0);
    wr(A_CTRL, ctrl_word(0, 1, 0));
    wr(A_LOAD, 32'd0);
    wr(A_CTRL, ctrl_word(0, 1, 1));
    cyc(20);
    chk("R8 zero load periodic no irq", 32'(irq), 0);

    // R6 counter rewrite mid-phase restarts the prescaler
    wr(A_CTRL, 0);
    wr(A_LOAD, 32'd10);
    wr(A_CTRL, ctrl_word(3, 0, 1));
    cyc(2);
    wr(A_CNT, 32'd2);
    cyc(7);
    chk("R6 no expiry before 2*(P+1)", 32'(irq), 0);
    cyc(1);
    chk("R6 expiry at 2*(P+1)", 32'(irq), 1);
    rd(A_CNT, v); chk("R4 one-shot parks at zero", v, 0);
    cyc(12);
    chk("R4 stays parked", 32'(irq), 1);
    rd(A_CNT, v); chk("R4 still zero", v, 0);

    // R10 clear semantics
    wr(A_STAT, 32'h0000_0002);
    chk("R10 write 0 to bit0 keeps irq", 32'(irq), 1);
    wr(A_STAT, 32'h1);
    chk("R10 W1C clears", 32'(irq), 0);
    rd(A_STAT, v); chk("R10 status reads zero", v, 0);

    // R10 expiry wins over same-edge clear (L=3, P=1, period 6)
    wr(A_CTRL, 0);
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, ctrl_word(1, 1, 1));
    cyc(5);
    chk("R5 before first expiry", 32'(irq), 0);
    cyc(1);
    chk("R5 first expiry", 32'(irq), 1);
    cyc(5);
    wr(A_STAT, 32'h1);
    chk("R10 expiry beats clear", 32'(irq), 1);
    wr(A_STAT, 32'h1);
    chk("R10 clear after collision", 32'(irq), 0);

    // Random one-shot and periodic runs (R3, R4, R5)
    for (int it = 0; it < 24; it++) begin
      int l, p, k, t;
      bit ar;
      l  = 1 + int'($urandom() % 20);
      p  = int'($urandom() % 4);
      ar = 1'($urandom());
      t  = l * (p + 1);
      k  = l / 2;
      wr(A_CTRL, 0);
      wr(A_STAT, 32'h1);
      wr(A_CTRL, ctrl_word(p, ar, 0));
      wr(A_LOAD, 32'(l));
      wr(A_CTRL, ctrl_word(p, ar, 1));
      cyc(k * (p + 1));
      rd(A_CNT, v); chk("R3 mid-run count", v, 32'(l - k));
      cyc(t - 1 - k * (p + 1));
      chk("R3 no early expiry", 32'(irq), 0);
      rd(A_CNT, v); chk("R3 count one before expiry", v, 32'd1);
      cyc(1);
      chk("R3 expiry on time", 32'(irq), 1);
      rd(A_CNT, v);
      if (ar) chk("R5 reload after expiry", v, 32'(l));
      else    chk("R4 zero after expiry", v, 0);
      if (ar) begin
        cyc(t);
        rd(A_CNT, v); chk("R5 second period reload", v, 32'(l));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule